// File: doc/BRIEF.md
# Smart-card T=0 character receiver

This block receives asynchronous half-duplex characters from a smart card over a single open-drain I/O line shared with the card. A character is a start bit, eight data bits sent least significant bit first, an even parity bit, and a guard time of two bit times. An oversampling enable, supplied from outside at `OVS` pulses per bit, times the character. Each bit is read at its midpoint. A start bit counts only if the line is still low at its middle.

When a character's parity is wrong, the receiver pulls the shared line low for one bit time as soon as the parity bit ends. This tells the card to send the character again, and it makes that character one bit time longer. A mode input suppresses this error signal. With the mode set, the bad character is still placed in the holding register, but the ready flag stays low and an inhibited-error flag is raised in its place. A saturating error counter counts every parity error and is cleared by a read strobe. Software sees the holding register, a ready flag, a parity-error flag, the inhibited-error flag and the error count through plain outputs and single-cycle strobes.

Top module: `t0_char_rx`

## Requirements
- R1: A character whose data XOR parity bit is 0 (even parity; the first data bit on the line is bit 0 of `rx_data`) is written to `rx_data`, and `rx_ready` is set.
- R2: A low level on the idle line that has ended before the middle of the start bit is ignored. No character is produced.
- R3: On a parity error with `inhibit_nack`=0, `line_drive_low` is 1 for exactly one bit time (`OVS` enable pulses), starting at the end of the parity bit. Otherwise `line_drive_low` stays 0.
- R4: A character with a parity error received with `inhibit_nack`=0 leaves `rx_data` and `rx_ready` unchanged and sets `parity_err`.
- R5: A character with a parity error received with `inhibit_nack`=1 drives no error bit and sets `nack_inh`. It is written to `rx_data`, but `rx_ready` is not raised.
- R6: `parity_err` and `nack_inh` stay set until a `clr_status_stb` pulse. Reads and later good characters do not clear them.
- R7: A `rd_data_stb` pulse clears `rx_ready`.
- R8: `err_count` increments by one for each parity error in either mode. A `rd_err_stb` pulse clears it to 0.
- R9: `err_count` saturates at 255 and does not wrap.
- R10: After reset, `rx_ready`, `parity_err`, `nack_inh`, `err_count` and `line_drive_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit time |
| line_in | input | 1 | Level read back from the shared I/O line (1 when released) |
| inhibit_nack | input | 1 | Mode: 1 suppresses the error bit |
| rd_data_stb | input | 1 | Holding-register read strobe, clears ready |
| rd_err_stb | input | 1 | Error-count read strobe, clears the count |
| clr_status_stb | input | 1 | Command strobe clearing both error flags |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | A good character is waiting |
| parity_err | output | 1 | Sticky parity-error flag (error bit sent) |
| nack_inh | output | 1 | Sticky flag: parity error with the error bit inhibited |
| err_count | output | 8 | Saturating parity-error count |

## Verification
The assertions assume that `inhibit_nack` does not change while a character is being received. They also assume that the strobes are single-cycle pulses that never coincide with the sampler's internal completion pulse in a way the flags could not resolve. The bench changes the mode only between characters, with the line idle. It issues each strobe for one clock while no character is in flight. It drives `line_in` as the wired-AND of its own transmitter and the block's drive enable, so the block reads back its own error bit in the same way it would on a real open-drain line.

// File: rtl/t0rx_pkg.sv
// Shared types for the T=0 receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package t0rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_TAIL,
        RX_ERRBIT
    } rx_state_e;

    localparam int DATA_BITS = 8;
endpackage

// File: rtl/t0rx_line_sync.sv
// Double-flop synchronizer for the shared I/O line.
// Assumes: the line idles high, so the flops reset to 1.
module t0rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] pipe_q;

    // Shift the line level through the synchronizer stages.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= line_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], line_async};
            end
        end
    endgenerate

    assign line_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/t0rx_frame_sampler.sv
// Character framing: start qualification, mid-bit sampling, parity check,
// and the error-bit window.
// Assumes: os_tick pulses OVS times per bit; OVS is even and at least 4;
// inhibit_nack is steady during a character.
module t0rx_frame_sampler
    import t0rx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 line,
    input  logic                 inhibit_nack,
    output logic                 char_done,
    output logic                 char_bad,
    output logic                 char_inh,
    output logic [DATA_BITS-1:0] char_data,
    output logic                 drive_low
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e              state_q;
    logic [CNT_W-1:0]       tick_cnt_q;
    logic [IDX_W-1:0]       bit_idx_q;
    logic [DATA_BITS-1:0]   shift_q;
    logic                   nack_pend_q;
    logic                   bad_now;

    // Parity outcome of the bit being sampled in the parity slot (even parity).
    assign bad_now = (^shift_q) ^ line;

    // Main framing state machine with tick counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RX_IDLE;
            tick_cnt_q  <= '0;
            bit_idx_q   <= '0;
            shift_q     <= '0;
            nack_pend_q <= 1'b0;
            char_done   <= 1'b0;
            char_bad    <= 1'b0;
            char_inh    <= 1'b0;
            char_data   <= '0;
        end else begin
            char_done <= 1'b0;
            if (os_tick) begin
                case (state_q)
                    RX_IDLE: begin
                        tick_cnt_q <= '0;
                        if (!line) state_q <= RX_START;
                    end
                    RX_START: begin
                        if (tick_cnt_q == HALF_LAST) begin
                            tick_cnt_q <= '0;
                            bit_idx_q  <= '0;
                            state_q    <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tick_cnt_q <= tick_cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tick_cnt_q == FULL_LAST) begin
                            tick_cnt_q <= '0;
                            shift_q    <= {line, shift_q[DATA_BITS-1:1]};
                            if (bit_idx_q == IDX_LAST) state_q <= RX_PARITY;
                            else bit_idx_q <= bit_idx_q + 1'b1;
                        end else begin
                            tick_cnt_q <= tick_cnt_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (tick_cnt_q == FULL_LAST) begin
                            tick_cnt_q  <= '0;
                            char_done   <= 1'b1;
                            char_bad    <= bad_now;
                            char_inh    <= bad_now & inhibit_nack;
                            char_data   <= shift_q;
                            nack_pend_q <= bad_now & ~inhibit_nack;
                            state_q     <= RX_TAIL;
                        end else begin
                            tick_cnt_q <= tick_cnt_q + 1'b1;
                        end
                    end
                    RX_TAIL: begin
                        if (tick_cnt_q == HALF_LAST) begin
                            tick_cnt_q <= '0;
                            state_q    <= nack_pend_q ? RX_ERRBIT : RX_IDLE;
                        end else begin
                            tick_cnt_q <= tick_cnt_q + 1'b1;
                        end
                    end
                    RX_ERRBIT: begin
                        if (tick_cnt_q == FULL_LAST) begin
                            tick_cnt_q  <= '0;
                            nack_pend_q <= 1'b0;
                            state_q     <= RX_IDLE;
                        end else begin
                            tick_cnt_q <= tick_cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // Open-drain pull-down active only during the error-bit window.
    assign drive_low = (state_q == RX_ERRBIT);

    // R3: the error bit is never driven while a character is being completed.
    a_r3_no_commit_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> !char_done);

    // R3: the error bit starts only after a character flagged bad without inhibit.
    a_r3_drive_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> (char_bad && !char_inh));
endmodule

// File: rtl/t0rx_err_counter.sv
// Saturating parity-error counter with clear-on-read.
// Assumes: rd_clr is a single-cycle pulse; an error in the clearing
// cycle is kept as a count of one.
module t0rx_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             incr,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count errors, hold at the maximum, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (rd_clr)                     count <= incr ? CNT_W'(1) : '0;
        else if (incr && (count != CNT_MAX)) count <= count + 1'b1;
    end

    // R9: a full counter stays full until read.
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !rd_clr) |=> (count == CNT_MAX));

    // R8: a read without a concurrent error leaves zero.
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !incr) |=> (count == '0));
endmodule

// File: rtl/t0rx_status.sv
// Holding register and status flags.
// Assumes: char_done is a one-cycle pulse with char_bad/char_inh/char_data valid.
module t0rx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_done,
    input  logic          char_bad,
    input  logic          char_inh,
    input  logic [DW-1:0] char_data,
    input  logic          rd_data_stb,
    input  logic          clr_status_stb,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          parity_err,
    output logic          nack_inh
);
    logic store_en;
    logic good_char;

    assign good_char = char_done & ~char_bad;
    assign store_en  = good_char | (char_done & char_inh);

    // Holding register: loads good characters and inhibited bad ones.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_data <= '0;
        else if (store_en) rx_data <= char_data;
    end

    // Ready flag: set by a good character, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)           rx_ready <= 1'b0;
        else if (good_char)   rx_ready <= 1'b1;
        else if (rd_data_stb) rx_ready <= 1'b0;
    end

    // Sticky error flags, cleared only by the status command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_err <= 1'b0;
            nack_inh   <= 1'b0;
        end else begin
            if (char_done && char_bad && !char_inh) parity_err <= 1'b1;
            else if (clr_status_stb)                parity_err <= 1'b0;
            if (char_done && char_inh)              nack_inh   <= 1'b1;
            else if (clr_status_stb)                nack_inh   <= 1'b0;
        end
    end

    // R6: the inhibited-error flag survives everything but the clear command.
    a_r6_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_inh && !clr_status_stb) |=> nack_inh);

    // R6: the parity-error flag is equally sticky.
    a_r6_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !clr_status_stb) |=> parity_err);

    // R5: an inhibited bad character does not raise ready.
    a_r5_inh_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && char_inh && !rx_ready) |=> !rx_ready);

    // R4: a bad character with the error bit sent leaves the holding register alone.
    a_r4_bad_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && char_bad && !char_inh) |=> $stable(rx_data));
endmodule

// File: rtl/t0_char_rx.sv
// Top level of the T=0 character receiver: synchronizer, framing,
// error counter and status/holding register.
// Assumes: os_tick is generated elsewhere at OVS pulses per bit time.
module t0_char_rx #(
    parameter int OVS         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             line_in,
    input  logic             inhibit_nack,
    input  logic             rd_data_stb,
    input  logic             rd_err_stb,
    input  logic             clr_status_stb,
    output logic             line_drive_low,
    output logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             parity_err,
    output logic             nack_inh,
    output logic [ERR_W-1:0] err_count
);
    import t0rx_pkg::*;

    logic                 line_s;
    logic                 char_done;
    logic                 char_bad;
    logic                 char_inh;
    logic [DATA_BITS-1:0] char_data;

    t0rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_in),
        .line_sync  (line_s)
    );

    t0rx_frame_sampler #(.OVS(OVS)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .line         (line_s),
        .inhibit_nack (inhibit_nack),
        .char_done    (char_done),
        .char_bad     (char_bad),
        .char_inh     (char_inh),
        .char_data    (char_data),
        .drive_low    (line_drive_low)
    );

    t0rx_err_counter #(.CNT_W(ERR_W)) u_errcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .incr   (char_done & char_bad),
        .rd_clr (rd_err_stb),
        .count  (err_count)
    );

    t0rx_status #(.DW(DATA_BITS)) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .char_done      (char_done),
        .char_bad       (char_bad),
        .char_inh       (char_inh),
        .char_data      (char_data),
        .rd_data_stb    (rd_data_stb),
        .clr_status_stb (clr_status_stb),
        .rx_data        (rx_data),
        .rx_ready       (rx_ready),
        .parity_err     (parity_err),
        .nack_inh       (nack_inh)
    );
endmodule

// File: tb/t0_char_rx_bench.sv
module t0_char_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 8;
    localparam int BIT_CLK    = 2 * OVS;   // os_tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       tx_line = 1'b1;
    logic       line_in;
    logic       inhibit_nack = 1'b0;
    logic       rd_data_stb = 1'b0;
    logic       rd_err_stb = 1'b0;
    logic       clr_status_stb = 1'b0;
    logic       line_drive_low;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       parity_err;
    logic       nack_inh;
    logic [7:0] err_count;

    int checks = 0;
    int failures = 0;
    int drv_total = 0;
    bit done = 1'b0;
    logic tick_div = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) tick_div <= ~tick_div;
    assign os_tick = tick_div;

    // Wired-AND open-drain line.
    assign line_in = tx_line & ~line_drive_low;

    always @(posedge clk) if (line_drive_low) drv_total <= drv_total + 1;

    t0_char_rx #(.OVS(OVS)) u_t0_char_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line_in),
        .inhibit_nack(inhibit_nack), .rd_data_stb(rd_data_stb),
        .rd_err_stb(rd_err_stb), .clr_status_stb(clr_status_stb),
        .line_drive_low(line_drive_low), .rx_data(rx_data), .rx_ready(rx_ready),
        .parity_err(parity_err), .nack_inh(nack_inh), .err_count(err_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        tx_line = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Sends one character; reports error-bit samples and drive cycles.
    task automatic send_char(input logic [7:0] d, input bit bad,
                             output int mid, output int late, output int cyc);
        int start_cnt;
        @(negedge clk);
        start_cnt = drv_total;
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit((^d) ^ bad);
        tx_line = 1'b1;
        repeat (BIT_CLK/2) @(negedge clk);
        mid = int'(line_drive_low);
        repeat (BIT_CLK) @(negedge clk);
        late = int'(line_drive_low);
        repeat (2 * BIT_CLK) @(negedge clk);
        cyc = drv_total - start_cnt;
    endtask

    task automatic t_reset;
        check("R10 ready", rx_ready, 0);
        check("R10 parity_err", parity_err, 0);
        check("R10 nack_inh", nack_inh, 0);
        check("R10 err_count", err_count, 0);
        check("R10 drive", line_drive_low, 0);
    endtask

    task automatic t_good(input logic [7:0] d);
        int m, l, c;
        send_char(d, 1'b0, m, l, c);
        check("R1 data", rx_data, d);
        check("R1 ready", rx_ready, 1);
        check("R3 no drive on good", c, 0);
        check("R1 no parity_err", parity_err, 0);
        pulse(rd_data_stb);
        check("R7 ready cleared", rx_ready, 0);
    endtask

    task automatic t_bad_nack(input logic [7:0] d, input logic [7:0] prev, input int cnt);
        int m, l, c;
        send_char(d, 1'b1, m, l, c);
        check("R3 drive mid error bit", m, 1);
        check("R3 released after", l, 0);
        check("R3 drive length", c, BIT_CLK);
        check("R4 parity_err", parity_err, 1);
        check("R4 data kept", rx_data, prev);
        check("R4 ready unchanged", rx_ready, 0);
        check("R8 count", err_count, cnt);
        pulse(clr_status_stb);
        check("R6 parity_err cleared", parity_err, 0);
    endtask

    task automatic t_inhibit(input logic [7:0] d, input int cnt);
        int m, l, c;
        inhibit_nack = 1'b1;
        send_char(d, 1'b1, m, l, c);
        inhibit_nack = 1'b0;
        check("R5 no drive", c, 0);
        check("R5 nack_inh", nack_inh, 1);
        check("R5 data stored", rx_data, d);
        check("R5 ready low", rx_ready, 0);
        check("R5 parity_err low", parity_err, 0);
        check("R8 count", err_count, cnt);
    endtask

    task automatic t_sticky;
        t_good(8'h11);
        pulse(rd_data_stb);
        check("R6 nack_inh stays", nack_inh, 1);
        pulse(clr_status_stb);
        check("R6 nack_inh cleared", nack_inh, 0);
    endtask

    task automatic t_glitch;
        @(negedge clk) tx_line = 1'b0;
        repeat (4) @(negedge clk);
        tx_line = 1'b1;
        repeat (14 * BIT_CLK) @(negedge clk);
        check("R2 glitch no ready", rx_ready, 0);
        check("R2 glitch data kept", rx_data, 8'h11);
        t_good(8'h42);
    endtask

    task automatic t_read_err;
        check("R8 count before read", err_count, 2);
        pulse(rd_err_stb);
        check("R8 cleared", err_count, 0);
    endtask

    task automatic t_saturate;
        int m, l, c;
        inhibit_nack = 1'b1;
        for (int k = 0; k < 257; k++) send_char(8'(k), 1'b1, m, l, c);
        inhibit_nack = 1'b0;
        check("R9 saturated", err_count, 255);
        pulse(rd_err_stb);
        check("R9 cleared after saturation", err_count, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_good(8'hA5);
        t_good(8'h00);
        t_good(8'hFF);
        t_good(8'h3C);
        t_bad_nack(8'h5A, 8'h3C, 1);
        t_inhibit(8'h81, 2);
        t_sticky();
        t_glitch();
        t_read_err();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule